// File: doc/BRIEF.md
# Status Register and Write-Protection Gate

This block sits beside the command decoder of a small serial memory. It keeps the protection fields of the memory's status register. For each write request it decides whether that write may go ahead. It also supplies the status byte that the read-status command shifts out. The decoder sends in one-cycle request pulses while chip select is low. The block answers each pulse with an accept flag. When chip select returns high, the block issues a one-cycle commit pulse for each write it accepted. Shifting bits and storing array data are done elsewhere.

Two protection layers combine:
- **Address-range protection.** A two-bit range field protects none of the array, its upper quarter, its upper half or all of it.
- **Hardware lock.** A lock-enable bit, together with a low level on the active-low protect pin, refuses every write.

A protect pin that falls while chip select is still low cancels any write that was accepted but not yet committed. Once the commit has been issued, the protect pin has no further effect on that write. While the internal write cycle runs, the status byte reads as all ones.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset the status byte is 0x00, and the accept and commit outputs are 0.
- R2: One cycle after `busy_i` is sampled high, `status_o` is 0xFF.
- R3: One cycle after `busy_i` is sampled low, `status_o` is laid out as follows. Bit 0 is 0 and bits 6..4 are 0. Bit 1 equals `wel_i`. Bits 3..2 hold the range field {BP1,BP0}. Bit 7 holds the lock-enable bit.
- R4: An array or status write request is refused when `wel_i` is 0 or `busy_i` is 1. The accept flag appears one cycle after the request.
- R5: The range field selects the protected addresses. Code 00 protects none. Code 01 protects addresses whose top two bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address. An array write to a protected address is refused.
- R6: With the lock-enable bit set and `wp_n_i` low, array writes and status writes are both refused, whatever `wel_i` is.
- R7: An accepted status write changes only the lock-enable bit and the range field. They take data bits 7, 3 and 2. All other data bits are ignored.
- R8: An accepted write that is still pending produces exactly one commit pulse, in the cycle after `cs_n_i` rises. A status write's new fields take effect at that same edge.
- R9: A falling edge on `wp_n_i` while `cs_n_i` is low cancels the pending writes. No commit follows, and the status fields are left unchanged.
- R10: A falling edge on `wp_n_i` after the commit has been issued does not undo it. A committed status write keeps its new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| wel_i | input | 1 | Write-enable latch state |
| busy_i | input | 1 | Internal write cycle in progress |
| arr_req_i | input | 1 | Array write request pulse |
| arr_addr_i | input | ADDR_W | Target array address |
| sr_req_i | input | 1 | Status write request pulse |
| sr_wdata_i | input | 8 | Status write data |
| arr_ok_o | output | 1 | Array write accepted |
| sr_ok_o | output | 1 | Status write accepted |
| arr_commit_o | output | 1 | Start internal array write |
| sr_commit_o | output | 1 | Status write committed |
| status_o | output | 8 | Status byte for read-status |

## Verification
The bench builds the block with a 4-bit address (16 locations). This makes every address in every protection range small enough to sweep in full. For each combination of range code and lock-enable bit it sweeps the protect pin, the write-enable latch and the busy flag, and tries a write to all 16 addresses. It predicts the accept flag and the commit pulse from the protection rules, and also checks the status byte. Directed sequences then cover the protect pin falling before and after chip select rises, and status writes that carry ignored bits.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef enum logic [1:0] {
    RANGE_NONE = 2'b00,
    RANGE_QTR  = 2'b01,
    RANGE_HALF = 2'b10,
    RANGE_ALL  = 2'b11
  } range_e;

  localparam int STAT_W   = 8;
  localparam int LOCK_BIT = 7;
  localparam int RNG_LO   = 2;
  localparam int WEL_BIT  = 1;
endpackage

// File: rtl/esg_range_cmp.sv
module esg_range_cmp
  import esg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  range_e            mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic top1;
  logic top2;

  assign top1 = addr[ADDR_W-1];

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top2 = addr[ADDR_W-1] & addr[ADDR_W-2];
    end else begin : g_narrow
      assign top2 = addr[0];
    end
  endgenerate

  always_comb begin
    unique case (mode)
      RANGE_NONE: hit = 1'b0;
      RANGE_QTR:  hit = top2;
      RANGE_HALF: hit = top1;
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/esg_wr_gate.sv
module esg_wr_gate
  import esg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              wel_i,
  input  logic              busy_i,
  input  logic              lock_en,
  input  logic              arr_req_i,
  input  logic              arr_hit,
  input  logic              sr_req_i,
  input  logic [STAT_W-1:0] sr_wdata_i,
  output logic              arr_ok_o,
  output logic              sr_ok_o,
  output logic              arr_commit_o,
  output logic              sr_commit_o,
  output logic              sr_apply,
  output logic [STAT_W-1:0] sr_apply_data
);
  logic wp_q, cs_q;
  logic pend_arr, pend_sr;
  logic [STAT_W-1:0] sr_data_q;
  logic hw_lock, base_ok, arr_allow, sr_allow;
  logic wp_fall, cancel, cs_rise;

  assign hw_lock   = lock_en & ~wp_n_i;
  assign base_ok   = wel_i & ~busy_i & ~hw_lock;
  assign arr_allow = arr_req_i & base_ok & ~arr_hit;
  assign sr_allow  = sr_req_i & base_ok;
  assign wp_fall   = wp_q & ~wp_n_i;
  assign cancel    = wp_fall & ~cs_n_i;
  assign cs_rise   = ~cs_q & cs_n_i;

  assign sr_apply      = cs_rise & pend_sr;
  assign sr_apply_data = sr_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q         <= 1'b1;
      cs_q         <= 1'b1;
      pend_arr     <= 1'b0;
      pend_sr      <= 1'b0;
      sr_data_q    <= '0;
      arr_ok_o     <= 1'b0;
      sr_ok_o      <= 1'b0;
      arr_commit_o <= 1'b0;
      sr_commit_o  <= 1'b0;
    end else begin
      wp_q         <= wp_n_i;
      cs_q         <= cs_n_i;
      arr_ok_o     <= arr_allow;
      sr_ok_o      <= sr_allow;
      arr_commit_o <= cs_rise & pend_arr;
      sr_commit_o  <= cs_rise & pend_sr;
      if (cancel || cs_rise) begin
        pend_arr <= 1'b0;
        pend_sr  <= 1'b0;
      end else begin
        if (arr_allow) pend_arr <= 1'b1;
        if (sr_allow) begin
          pend_sr   <= 1'b1;
          sr_data_q <= sr_wdata_i;
        end
      end
    end
  end

  // R6: the hardware lock refuses both kinds of write
  p_lock_refuses_r6: assert property (@(posedge clk) disable iff (rst)
    ((arr_req_i || sr_req_i) && lock_en && !wp_n_i) |=> (!arr_ok_o && !sr_ok_o));

  // R4: nothing is accepted while the internal cycle runs
  p_busy_refuses_r4: assert property (@(posedge clk) disable iff (rst)
    ((arr_req_i || sr_req_i) && busy_i) |=> (!arr_ok_o && !sr_ok_o));

  // R9: a protect-pin fall with select low empties the pending writes
  p_wp_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(wp_n_i) && !cs_n_i) |=> (!pend_arr && !pend_sr));

  // R8: a commit only follows chip select going high
  p_commit_on_cs_r8: assert property (@(posedge clk) disable iff (rst)
    (arr_commit_o || sr_commit_o) |-> $past(cs_n_i));
endmodule

// File: rtl/esg_stat_bits.sv
module esg_stat_bits
  import esg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              apply,
  input  logic [STAT_W-1:0] wdata,
  input  logic              wel_i,
  input  logic              busy_i,
  output range_e            range_q,
  output logic              lock_q,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] idle_byte;

  always_comb begin
    idle_byte                    = '0;
    idle_byte[LOCK_BIT]          = lock_q;
    idle_byte[RNG_LO+1:RNG_LO]   = range_q;
    idle_byte[WEL_BIT]           = wel_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      range_q  <= RANGE_NONE;
      lock_q   <= 1'b0;
      status_o <= '0;
    end else begin
      if (apply) begin
        range_q <= range_e'(wdata[RNG_LO+1:RNG_LO]);
        lock_q  <= wdata[LOCK_BIT];
      end
      status_o <= busy_i ? {STAT_W{1'b1}} : idle_byte;
    end
  end

  // R2: all ones while a write cycle runs
  p_busy_ones_r2: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (status_o == {STAT_W{1'b1}}));

  // R3: idle byte has busy bit and the spare bits clear
  p_idle_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_i |=> (status_o[6:4] == 3'b000 && !status_o[0]));
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import esg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              wel_i,
  input  logic              busy_i,
  input  logic              arr_req_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              sr_req_i,
  input  logic [7:0]        sr_wdata_i,
  output logic              arr_ok_o,
  output logic              sr_ok_o,
  output logic              arr_commit_o,
  output logic              sr_commit_o,
  output logic [7:0]        status_o
);
  range_e            range_q;
  logic              lock_q;
  logic              arr_hit;
  logic              sr_apply;
  logic [STAT_W-1:0] sr_apply_data;

  esg_range_cmp #(.ADDR_W(ADDR_W)) u_range (
    .mode (range_q),
    .addr (arr_addr_i),
    .hit  (arr_hit)
  );

  esg_wr_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .cs_n_i       (cs_n_i),
    .wp_n_i       (wp_n_i),
    .wel_i        (wel_i),
    .busy_i       (busy_i),
    .lock_en      (lock_q),
    .arr_req_i    (arr_req_i),
    .arr_hit      (arr_hit),
    .sr_req_i     (sr_req_i),
    .sr_wdata_i   (sr_wdata_i),
    .arr_ok_o     (arr_ok_o),
    .sr_ok_o      (sr_ok_o),
    .arr_commit_o (arr_commit_o),
    .sr_commit_o  (sr_commit_o),
    .sr_apply     (sr_apply),
    .sr_apply_data(sr_apply_data)
  );

  esg_stat_bits u_bits (
    .clk     (clk),
    .rst     (rst),
    .apply   (sr_apply),
    .wdata   (sr_apply_data),
    .wel_i   (wel_i),
    .busy_i  (busy_i),
    .range_q (range_q),
    .lock_q  (lock_q),
    .status_o(status_o)
  );

  // R5: the whole-array setting refuses every address
  p_full_range_r5: assert property (@(posedge clk) disable iff (rst)
    (arr_req_i && range_q == RANGE_ALL) |=> !arr_ok_o);
endmodule

// File: tb/eeprom_status_guard_tb_top.sv
`timescale 1ns/1ps
module eeprom_status_guard_tb_top;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wp_n = 1'b1, wel = 1'b0, busy = 1'b0;
  logic arr_req = 1'b0, sr_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic arr_ok, sr_ok, arr_commit, sr_commit;
  logic [7:0] status;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_status_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .wp_n_i(wp_n), .wel_i(wel),
    .busy_i(busy), .arr_req_i(arr_req), .arr_addr_i(addr), .sr_req_i(sr_req),
    .sr_wdata_i(wdata), .arr_ok_o(arr_ok), .sr_ok_o(sr_ok),
    .arr_commit_o(arr_commit), .sr_commit_o(sr_commit), .status_o(status)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit in_range(input int code, input int a);
    case (code)
      0: return 1'b0;
      1: return a >= (DEPTH * 3) / 4;
      2: return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic sr_write(input logic [7:0] d, output logic ok, output logic cm);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); sr_req = 1'b1; wdata = d;
    @(negedge clk); sr_req = 1'b0; ok = sr_ok; cs_n = 1'b1;
    @(negedge clk); cm = sr_commit;
    @(negedge clk);
  endtask

  task automatic arr_write(input int a, output logic ok, output logic cm);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); arr_req = 1'b1; addr = AW'(a);
    @(negedge clk); arr_req = 1'b0; ok = arr_ok; cs_n = 1'b1;
    @(negedge clk); cm = arr_commit;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic ok, cm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 outputs", {arr_ok, sr_ok, arr_commit, sr_commit}, 0);

    // Sweep: range code, lock bit, pin, latch, busy, every address (R2..R6, R8)
    for (int code = 0; code < 4; code++) begin
      for (int lk = 0; lk < 2; lk++) begin
        wel = 1'b1; wp_n = 1'b1; busy = 1'b0;
        sr_write({lk[0], 3'b000, code[1:0], 2'b00}, ok, cm);
        check("R8 config commit", cm, 1);
        for (int w = 0; w < 2; w++) begin
          for (int e = 0; e < 2; e++) begin
            for (int b = 0; b < 2; b++) begin
              @(negedge clk); wp_n = w[0]; wel = e[0]; busy = b[0];
              @(negedge clk);
              if (b) check("R2 busy byte", status, 8'hFF);
              else   check("R3 idle byte", status,
                           {lk[0], 3'b000, code[1:0], e[0], 1'b0});
              for (int a = 0; a < DEPTH; a++) begin
                bit exp;
                exp = e[0] && !b[0] && !(lk[0] && !w[0]) && !in_range(code, a);
                arr_write(a, ok, cm);
                check("R4/R5/R6 accept", ok, exp);
                check("R8 commit", cm, exp);
              end
            end
          end
        end
      end
    end

    // R7: ignored data bits
    @(negedge clk); wp_n = 1'b1; wel = 1'b1; busy = 1'b0;
    sr_write(8'h7F, ok, cm);
    check("R7 commit", cm, 1);
    check("R7 byte", status, 8'h0E);

    // R6: status write refused under hardware lock
    sr_write(8'h80, ok, cm);
    check("R6 setup byte", status, 8'h82);
    @(negedge clk); wp_n = 1'b0;
    sr_write(8'h0C, ok, cm);
    check("R6 sr accept", ok, 0);
    check("R6 sr commit", cm, 0);
    check("R6 byte kept", status, 8'h82);

    // R9: protect pin falls with select low
    @(negedge clk); wp_n = 1'b1;
    sr_write(8'h00, ok, cm);
    check("R9 setup byte", status, 8'h02);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); arr_req = 1'b1; addr = '0;
    @(negedge clk); arr_req = 1'b0; ok = arr_ok; wp_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    check("R9 arr accepted", ok, 1);
    check("R9 arr no commit", arr_commit, 0);
    @(negedge clk); wp_n = 1'b1; cs_n = 1'b0;
    @(negedge clk); sr_req = 1'b1; wdata = 8'h0C;
    @(negedge clk); sr_req = 1'b0; wp_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    check("R9 sr no commit", sr_commit, 0);
    @(negedge clk);
    check("R9 byte kept", status, 8'h02);

    // R10: protect pin falls after the commit
    @(negedge clk); wp_n = 1'b1; cs_n = 1'b0;
    @(negedge clk); sr_req = 1'b1; wdata = 8'h84;
    @(negedge clk); sr_req = 1'b0; cs_n = 1'b1;
    @(negedge clk); cm = sr_commit; wp_n = 1'b0; busy = 1'b1;
    check("R10 commit", cm, 1);
    @(negedge clk);
    check("R10 busy byte", status, 8'hFF);
    busy = 1'b0;
    @(negedge clk);
    check("R10 byte kept", status, 8'h86);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule